// File: doc/BRIEF.md
# Extended PHY Register Access Sequencer

This block lets a controller reach the extended register space of an Ethernet PHY when only a basic management frame engine is available. One request names the PHY, a 5-bit device address, a 16-bit register number, write data and a read/write flag. The block turns that request into four basic management accesses, one after another. The accesses alternate between a control register and an address/data register. A command field in the control value selects whether the next address/data access carries an address or data.

The frame engine is modelled as a request/acknowledge port. The block holds a step on that port until the engine acknowledges it, and then moves on to the next step. After the fourth acknowledge the block raises `done` for one cycle. For a read, the returned word is on `rd_data` in that same cycle.

The state machine has six states:
- `S_IDLE`: waits for a request.
- `S_CTL_ADDR`: writes the control register with the address command.
- `S_REG_NUM`: writes the register number.
- `S_CTL_DATA`: writes the control register with the data command.
- `S_XFER`: performs the final read or write of the address/data register.
- `S_DONE`: the completion cycle.

Transitions:
- IDLE→CTL_ADDR on `req_valid`.
- Each step state moves to the next one on `fe_ack`.
- XFER→DONE on `fe_ack`.
- DONE→IDLE unconditionally.

Top module: `xreg_bridge`

## Requirements
- R1: After reset, `busy`, `done` and `fe_req` are 0 and `rd_data` is 0.
- R2: A request is accepted only in `S_IDLE`. While `busy` is high, `req_valid` is ignored: the ongoing sequence keeps its own fields and no extra accesses are issued.
- R3: Step 1 is a write to register address 0x0D, using the requested PHY address. Its data has bits 15:14 = 00 (address command), bits 4:0 = device address, and all other bits 0.
- R4: Step 2 is a write to register address 0x0E. Its data is the 16-bit register number.
- R5: Step 3 is a write to register address 0x0D. Its data has bits 15:14 = 01 (data command), bits 4:0 = device address, and all other bits 0, so the value is 0x4000 | device.
- R6: For a write request, step 4 is a write to 0x0E carrying the write data.
- R7: For a read request, step 4 is a read of 0x0E. The engine's returned word appears on `rd_data` in the cycle in which `done` is high.
- R8: While `fe_req` is high and `fe_ack` is low, `fe_write`, `fe_reg`, `fe_phy` and `fe_wdata` stay stable. The next step is presented only after an acknowledge.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle, and low in the following cycle.
- R10: `rd_data` changes only in a `done` cycle of a read. A write leaves it unchanged.
- R11: Each request produces exactly four acknowledged engine accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_dev | input | 5 | Device address |
| req_reg | input | 16 | Extended register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| fe_req | output | 1 | Step request to frame engine |
| fe_write | output | 1 | Step direction, 1 = write |
| fe_phy | output | 5 | Step PHY address |
| fe_reg | output | 5 | Step register address |
| fe_wdata | output | 16 | Step write data |
| fe_ack | input | 1 | Engine acknowledge, one cycle |
| fe_rdata | input | 16 | Engine read data, valid with ack |

## Verification
A wrong state shows up at the frame port on the very next acknowledge. A skipped or repeated step changes the register address or data of the logged access, and it changes the count of four accesses seen before `done`. A request latch that is corrupted while busy shows up as altered fields in the remaining steps. A bad completion path shows up within one cycle of the final acknowledge, as a missing or stretched `done` pulse, a lingering `busy`, or a wrong `rd_data`. Engine latencies of zero and several cycles expose any step that advances without waiting for its acknowledge.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    localparam int PHY_W  = 5;
    localparam int DEV_W  = 5;
    localparam int REG_W  = 5;
    localparam int WORD_W = 16;
    localparam int CMD_LSB = 14;

    localparam logic [REG_W-1:0] CTL_REG  = 5'h0D;
    localparam logic [REG_W-1:0] DATA_REG = 5'h0E;
    localparam logic [1:0] CMD_ADDR = 2'd0;
    localparam logic [1:0] CMD_DATA = 2'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTL_ADDR,
        S_REG_NUM,
        S_CTL_DATA,
        S_XFER,
        S_DONE
    } step_t;

    typedef struct packed {
        logic              wr;
        logic [PHY_W-1:0]  phy;
        logic [DEV_W-1:0]  dev;
        logic [WORD_W-1:0] regnum;
        logic [WORD_W-1:0] wdata;
    } xreq_t;

    function automatic logic [WORD_W-1:0] ctl_word(input logic [1:0] cmd,
                                                   input logic [DEV_W-1:0] dev);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CMD_LSB +: 2] = cmd;
        w[DEV_W-1:0]    = dev;
        return w;
    endfunction
endpackage

// File: rtl/xreg_req_hold.sv
module xreg_req_hold
    import xreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  xreq_t d,
    output xreq_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/xreg_frame_mux.sv
module xreg_frame_mux
    import xreg_pkg::*;
(
    input  step_t              step,
    input  xreq_t              rq,
    output logic               fe_write,
    output logic [REG_W-1:0]   fe_reg,
    output logic [WORD_W-1:0]  fe_wdata
);
    always_comb begin
        fe_write = 1'b1;
        fe_reg   = CTL_REG;
        fe_wdata = '0;
        unique case (step)
            S_CTL_ADDR: begin
                fe_reg   = CTL_REG;
                fe_wdata = ctl_word(CMD_ADDR, rq.dev);
            end
            S_REG_NUM: begin
                fe_reg   = DATA_REG;
                fe_wdata = rq.regnum;
            end
            S_CTL_DATA: begin
                fe_reg   = CTL_REG;
                fe_wdata = ctl_word(CMD_DATA, rq.dev);
            end
            S_XFER: begin
                fe_reg   = DATA_REG;
                fe_write = rq.wr;
                fe_wdata = rq.wr ? rq.wdata : '0;
            end
            S_IDLE, S_DONE: begin
                fe_write = 1'b0;
                fe_reg   = '0;
                fe_wdata = '0;
            end
            default: begin
                fe_write = 1'b0;
                fe_reg   = '0;
                fe_wdata = '0;
            end
        endcase
    end

    // R3/R5: control-register data never has stray bits between the fields
    always_comb begin
        if (step == S_CTL_ADDR || step == S_CTL_DATA)
            a_ctl_clean_r3: assert (fe_wdata[CMD_LSB-1:DEV_W] == '0);
    end
endmodule

// File: rtl/xreg_bridge.sv
module xreg_bridge
    import xreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [WORD_W-1:0] req_reg,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              fe_req,
    output logic              fe_write,
    output logic [PHY_W-1:0]  fe_phy,
    output logic [REG_W-1:0]  fe_reg,
    output logic [WORD_W-1:0] fe_wdata,
    input  logic              fe_ack,
    input  logic [WORD_W-1:0] fe_rdata
);
    step_t state, state_nx;
    xreq_t rq_in, rq;
    logic  accept;

    assign accept = (state == S_IDLE) && req_valid;
    assign rq_in  = '{wr: req_write, phy: req_phy, dev: req_dev,
                      regnum: req_reg, wdata: req_wdata};

    xreg_req_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     (rq_in),
        .q     (rq)
    );

    xreg_frame_mux u_mux (
        .step     (state),
        .rq       (rq),
        .fe_write (fe_write),
        .fe_reg   (fe_reg),
        .fe_wdata (fe_wdata)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_CTL_ADDR;
            S_CTL_ADDR: if (fe_ack)    state_nx = S_REG_NUM;
            S_REG_NUM:  if (fe_ack)    state_nx = S_CTL_DATA;
            S_CTL_DATA: if (fe_ack)    state_nx = S_XFER;
            S_XFER:     if (fe_ack)    state_nx = S_DONE;
            S_DONE:                    state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // read result register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (state == S_XFER && fe_ack && !rq.wr)
            rd_data <= fe_rdata;
    end

    // outputs
    always_comb begin
        fe_req = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            S_IDLE:  busy = 1'b0;
            S_DONE:  done = 1'b1;
            S_CTL_ADDR, S_REG_NUM, S_CTL_DATA, S_XFER: fe_req = 1'b1;
            default: busy = 1'b0;
        endcase
    end
    assign fe_phy = rq.phy;

    // ---------------- assertions ----------------
    p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && !fe_ack |=> fe_req && $stable(fe_reg) && $stable(fe_wdata)
                              && $stable(fe_write) && $stable(fe_phy));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !fe_req);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fe_req && !done);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid |=> busy && fe_req);

    p_rd_only_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

    p_final_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && !fe_write |-> fe_reg == DATA_REG);
endmodule

// File: tb/sim_xreg_bridge.sv
module sim_xreg_bridge;
    import xreg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_phy = '0, req_dev = '0;
    logic [15:0] req_reg = '0, req_wdata = '0;
    logic busy, done, fe_req, fe_write;
    logic [15:0] rd_data, fe_wdata;
    logic [4:0] fe_phy, fe_reg;
    logic fe_ack = 1'b0;
    logic [15:0] fe_rdata = '0;

    always #5 clk = ~clk;

    xreg_bridge u0 (.*);

    int errors = 0, checks = 0;
    int lat = 0;
    int n_fr = 0;
    logic        fr_w   [0:15];
    logic [4:0]  fr_reg [0:15];
    logic [4:0]  fr_phy [0:15];
    logic [15:0] fr_dat [0:15];
    int hold_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // frame engine model: acknowledges after lat waiting cycles, logs each step
    initial begin
        int cnt = 0;
        logic [4:0] p_reg = '0;
        logic [15:0] p_dat = '0;
        logic p_w = 1'b0, p_live = 1'b0;
        forever begin
            @(negedge clk);
            if (fe_ack) begin
                fe_ack = 1'b0;
                cnt = 0;
                p_live = 1'b0;
            end else if (fe_req) begin
                if (p_live && (p_reg !== fe_reg || p_dat !== fe_wdata || p_w !== fe_write))
                    hold_err++;
                p_live = 1'b1;
                p_reg = fe_reg; p_dat = fe_wdata; p_w = fe_write;
                if (cnt >= lat) begin
                    fe_ack = 1'b1;
                    if (n_fr < 16) begin
                        fr_w[n_fr] = fe_write; fr_reg[n_fr] = fe_reg;
                        fr_phy[n_fr] = fe_phy; fr_dat[n_fr] = fe_wdata;
                    end
                    n_fr++;
                end else
                    cnt++;
            end
        end
    end

    // one request; optionally keep req_valid high with other fields while busy
    task automatic xfer(input logic wr, input logic [4:0] phy, input logic [4:0] dev,
                        input logic [15:0] rg, input logic [15:0] wd,
                        input logic [15:0] rv, input bit noise);
        logic [15:0] rd_before;
        bit seen = 0;
        rd_before = rd_data;
        n_fr = 0; hold_err = 0;
        fe_rdata = rv;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_phy = phy; req_dev = dev;
        req_reg = rg; req_wdata = wd;
        @(negedge clk);
        chk("R9 busy after accept", busy, 1);
        if (noise) begin
            req_write = ~wr; req_phy = ~phy; req_dev = ~dev; req_reg = ~rg; req_wdata = ~wd;
            repeat (4) @(negedge clk);
        end
        req_valid = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            if (!wr || i > 0) ;
            @(negedge clk);
        end
        chk("R9 done seen", seen, 1);
        chk("R9 busy with done", busy, 1);
        if (!wr) chk("R7 rd_data at done", rd_data, rv);
        else     chk("R10 rd_data kept on write", rd_data, rd_before);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 busy low after done", busy, 0);
        chk("R11 four accesses", n_fr, 4);
        chk("R8 fields held until ack", hold_err, 0);
        if (n_fr == 4) begin
            chk("R3 step1 reg", {fr_w[0], fr_reg[0]}, {1'b1, 5'h0D});
            chk("R3 step1 data", fr_dat[0], {11'd0, dev});
            chk("R3 phy", fr_phy[0], phy);
            chk("R4 step2", {fr_w[1], fr_reg[1], fr_dat[1]}, {1'b1, 5'h0E, rg});
            chk("R5 step3", {fr_w[2], fr_reg[2], fr_dat[2]}, {1'b1, 5'h0D, 16'h4000 | dev});
            if (wr) chk("R6 step4 write", {fr_w[3], fr_reg[3], fr_dat[3]}, {1'b1, 5'h0E, wd});
            else    chk("R7 step4 read", {fr_w[3], fr_reg[3]}, {1'b0, 5'h0E});
            chk("R2 phy kept", fr_phy[3], phy);
        end
        repeat (3) @(negedge clk);
        chk("R2 no extra access", n_fr, 4);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 fe_req", fe_req, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_write_basic;
        lat = 2;
        xfer(1, 5'h03, 5'h1F, 16'hA5C3, 16'h1234, 16'hDEAD, 0);
    endtask

    task automatic t_read_basic;
        lat = 1;
        xfer(0, 5'h11, 5'h07, 16'h8001, 16'h0000, 16'hBEEF, 0);
    endtask

    task automatic t_latency_edges;
        lat = 0;
        xfer(0, 5'h00, 5'h00, 16'h0000, 16'h0, 16'hFFFF, 0);
        lat = 6;
        xfer(1, 5'h1F, 5'h15, 16'hFFFF, 16'h5A5A, 16'h0, 0);
    endtask

    task automatic t_busy_ignore;
        lat = 2;
        xfer(0, 5'h0A, 5'h03, 16'h0123, 16'h0, 16'h7E81, 1);
        xfer(1, 5'h05, 5'h1E, 16'h4321, 16'hC0DE, 16'h0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_latency_edges();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule